// File: doc/BRIEF.md
# I2C Master Command Queue

This block sits between a 32-bit register bus and the byte-level engine of an I2C master. Software drives a transfer through a single data/command register. Each write to that register queues one 10-bit command word. The word holds either a byte to transmit or a request to read one byte, and it can also ask the engine to end the transfer with a STOP. Each read of the same register takes the oldest byte the engine has returned.

The engine takes command words from the transmit queue and hands received bytes back to the receive queue. Both sides use a valid/ready handshake. The block also:
- reports the fill level of each queue;
- compares each level against a programmable threshold to raise two level-sensitive status flags;
- raises one-cycle event pulses for pushes that are dropped, pops from an empty queue and receive overruns.

An abort from the engine empties both queues, and so does clearing the enable register.

Top module: `i2c_cmd_queue`

## Requirements
- R1: A command word written to offset 0x10 is delivered on `cmd_data` unchanged, in write order. Bits 7:0 are the byte to send, bit 8 set means "read one byte" and bit 9 set means "issue STOP after this byte".
- R2: `cmd_valid` is high whenever the block is enabled and the transmit queue is not empty. A word leaves the queue at a clock edge where both `cmd_valid` and `cmd_ready` are high. While the engine holds `cmd_ready` low, `cmd_data` stays stable.
- R3: The transmit fill level reads back at offset 0x74 and the receive fill level at offset 0x78, each in the low bits of the word. Each level lies between 0 and DEPTH.
- R4: The transmit threshold is at offset 0x3C and the receive threshold at offset 0x38, and both read back as written. `st_tx_low` is high while the transmit level is at or below its threshold. `st_rx_high` is high while the receive level is above its threshold.
- R5: A write to 0x10 while the transmit queue holds DEPTH words is dropped, and `ev_tx_over` pulses high for one cycle after that write.
- R6: A read of 0x10 returns the oldest received byte in bits 7:0, with the upper bits zero, and removes it. A read while the receive queue is empty returns 0 and pulses `ev_rx_under` for one cycle.
- R7: `rx_ready` is always high. A byte offered while the receive queue is full is dropped and pulses `ev_rx_over` for one cycle.
- R8: A cycle with `abort` high empties both queues, and both levels read 0 afterwards.
- R9: The enable register is bit 0 of offset 0x6C. While it holds 0, `cmd_valid` is low, both queues are held empty, and writes to 0x10, reads of 0x10 and incoming bytes are all ignored without raising any event.
- R10: After reset both levels, both thresholds and the enable register read 0. `st_tx_low` is then high, `st_rx_high` is low and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, combinational |
| cmd_valid | output | 1 | A command word is offered to the engine |
| cmd_ready | input | 1 | The engine takes the offered word |
| cmd_data | output | 10 | Command word {stop, read, byte} |
| rx_valid | input | 1 | The engine offers a received byte |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 8 | Received byte |
| abort | input | 1 | Transfer aborted, flush both queues |
| st_tx_low | output | 1 | Transmit level at or below its threshold |
| st_rx_high | output | 1 | Receive level above its threshold |
| ev_tx_over | output | 1 | Pulse: a push was dropped because the transmit queue was full |
| ev_rx_under | output | 1 | Pulse: a read found the receive queue empty |
| ev_rx_over | output | 1 | Pulse: a received byte was dropped because the receive queue was full |

## Verification
The scoreboard checks every command word, including its read and STOP bits. A design that reordered words or dropped control bits would send the engine a corrupted transfer.

The bench goes after the queue boundaries:
- the push one word beyond full, where a design that wrapped its pointer would overwrite the oldest word;
- a pop from an empty queue, which must return zero;
- the receive byte one beyond full, which must be dropped.

Threshold flags are probed one step either side of the comparison point, which catches a flag compared with < where <= is required.

Abort and disable are applied with both queues loaded, and then the engine is allowed to accept. A design that flushed only one queue would leak stale commands or stale bytes.

// File: rtl/icq_pkg.sv
`timescale 1ns/1ps
package icq_pkg;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned REG_AW   = 8;
  localparam int unsigned CMD_W    = 10;
  localparam int unsigned BYTE_W   = 8;
  // register offsets
  localparam logic [REG_AW-1:0] OFS_DATA   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_RX_THR = 8'h38;
  localparam logic [REG_AW-1:0] OFS_TX_THR = 8'h3C;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h6C;
  localparam logic [REG_AW-1:0] OFS_TX_LVL = 8'h74;
  localparam logic [REG_AW-1:0] OFS_RX_LVL = 8'h78;
endpackage

// File: rtl/icq_fifo.sv
`timescale 1ns/1ps
module icq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign rdata   = mem_q[rd_q];
  assign level   = lvl_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end

  // R3: level never leaves 0..DEPTH
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
  // R8: a flush leaves the queue empty
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lvl_q == '0));
  // R5: a push into a full queue does not change the level
  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (lvl_q == LW'(DEPTH)));
endmodule

// File: rtl/icq_regs.sv
`timescale 1ns/1ps
module icq_regs
  import icq_pkg::*;
#(
  parameter int unsigned LW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic [LW-1:0]     tx_level,
  input  logic [LW-1:0]     rx_level,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_head,
  output logic              en,
  output logic [LW-1:0]     tx_thr,
  output logic [LW-1:0]     rx_thr,
  output logic              push_tx,
  output logic [CMD_W-1:0]  push_word,
  output logic              pop_rx,
  output logic              ev_tx_over,
  output logic              ev_rx_under
);
  logic          en_q, en_d;
  logic [LW-1:0] txt_q, txt_d, rxt_q, rxt_d;
  logic          txo_q, txo_d, rxu_q, rxu_d;
  logic          wr_acc, rd_acc;
  logic          unused_wdata;

  assign wr_acc       = req & we;
  assign rd_acc       = req & ~we;
  assign push_tx      = wr_acc & (addr == OFS_DATA) & en_q;
  assign pop_rx       = rd_acc & (addr == OFS_DATA) & en_q;
  assign push_word    = wdata[CMD_W-1:0];
  assign unused_wdata = ^wdata[REG_DW-1:CMD_W];

  always_comb begin
    en_d  = en_q;
    txt_d = txt_q;
    rxt_d = rxt_q;
    if (wr_acc && addr == OFS_ENABLE) en_d  = wdata[0];
    if (wr_acc && addr == OFS_TX_THR) txt_d = wdata[LW-1:0];
    if (wr_acc && addr == OFS_RX_THR) rxt_d = wdata[LW-1:0];
    txo_d = push_tx & tx_full;
    rxu_d = pop_rx & rx_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      txt_q <= '0;
      rxt_q <= '0;
      txo_q <= 1'b0;
      rxu_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      txt_q <= txt_d;
      rxt_q <= rxt_d;
      txo_q <= txo_d;
      rxu_q <= rxu_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_DATA:   rdata = (en_q && !rx_empty) ? REG_DW'(rx_head) : '0;
      OFS_RX_THR: rdata = REG_DW'(rxt_q);
      OFS_TX_THR: rdata = REG_DW'(txt_q);
      OFS_ENABLE: rdata = REG_DW'(en_q);
      OFS_TX_LVL: rdata = REG_DW'(tx_level);
      OFS_RX_LVL: rdata = REG_DW'(rx_level);
      default:    rdata = '0;
    endcase
  end

  assign en          = en_q;
  assign tx_thr      = txt_q;
  assign rx_thr      = rxt_q;
  assign ev_tx_over  = txo_q;
  assign ev_rx_under = rxu_q;

  // R6: an underrun pulse only follows an empty receive queue
  p_under_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rxu_q |-> $past(rx_empty));
endmodule

// File: rtl/i2c_cmd_queue.sv
`timescale 1ns/1ps
module i2c_cmd_queue
  import icq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [9:0]  cmd_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        abort,
  output logic        st_tx_low,
  output logic        st_rx_high,
  output logic        ev_tx_over,
  output logic        ev_rx_under,
  output logic        ev_rx_over
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic              en, flush;
  logic [LW-1:0]     tx_level, rx_level, tx_thr, rx_thr;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              push_tx, pop_rx, take_cmd, push_rx;
  logic [CMD_W-1:0]  push_word;
  logic [BYTE_W-1:0] rx_head;
  logic              rxo_q, rxo_d;

  assign flush    = abort | ~en;
  assign take_cmd = cmd_valid & cmd_ready;
  assign push_rx  = rx_valid & en;
  assign rx_ready = 1'b1;

  icq_regs #(.LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req(reg_req), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_head(rx_head), .en(en), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .push_tx(push_tx), .push_word(push_word), .pop_rx(pop_rx),
    .ev_tx_over(ev_tx_over), .ev_rx_under(ev_rx_under)
  );

  icq_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push_tx), .wdata(push_word), .pop(take_cmd), .rdata(cmd_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  icq_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push_rx), .wdata(rx_data), .pop(pop_rx), .rdata(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid  = en & ~tx_empty;
  assign st_tx_low  = (tx_level <= tx_thr);
  assign st_rx_high = (rx_level > rx_thr);

  always_comb rxo_d = push_rx & rx_full & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxo_q <= 1'b0;
    else        rxo_q <= rxo_d;
  end
  assign ev_rx_over = rxo_q;

  // R9: while disabled both queues drain to empty
  p_disabled_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_level == '0 && rx_level == '0));
  // R5: overrun pulse only after a full transmit queue
  p_tx_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_over |-> $past(tx_full));
  // R7: receive overrun only after a full receive queue
  p_rx_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_over |-> $past(rx_full));
  // R2: a stalled word is held stable
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort) |=> (!en || (cmd_valid && $stable(cmd_data))));
endmodule

// File: tb/test_i2c_cmd_queue.sv
`timescale 1ns/1ps
module test_i2c_cmd_queue;
  import icq_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 0, reg_we = 0, cmd_ready = 0, rx_valid = 0, abort = 0;
  logic [7:0]  reg_addr = '0, rx_data = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cmd_valid, rx_ready, st_tx_low, st_rx_high;
  logic        ev_tx_over, ev_rx_under, ev_rx_over;
  logic [9:0]  cmd_data;

  i2c_cmd_queue #(.DEPTH(DEPTH)) i_i2c_cmd_queue (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .abort(abort), .st_tx_low(st_tx_low), .st_rx_high(st_rx_high),
    .ev_tx_over(ev_tx_over), .ev_rx_under(ev_rx_under), .ev_rx_over(ev_rx_over)
  );

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  logic [9:0] exp_cmd[$];
  logic [7:0] exp_rx[$];
  int  tx_model = 0, rx_model = 0;
  bit  en_model = 0;
  logic s_ev;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    #1 s_ev = ev_tx_over;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_req = 0;
    #1 s_ev = ev_rx_under;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] expv);
    logic [31:0] v;
    bus_read(a, v);
    chk(tag, v, expv);
  endtask

  // driver: pushes a command and records what the engine should see
  task automatic push_cmd(logic [9:0] w);
    bit over;
    over = en_model && (tx_model == DEPTH);
    bus_write(OFS_DATA, {22'b0, w});
    if (en_model && !over) begin exp_cmd.push_back(w); tx_model++; end
    chk("R5 ev_tx_over after push", s_ev, over);
  endtask

  task automatic send_rx(logic [7:0] b);
    bit over;
    over = en_model && (rx_model == DEPTH);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
    #1 chk("R7 ev_rx_over after byte", ev_rx_over, over);
    if (en_model && !over) begin exp_rx.push_back(b); rx_model++; end
  endtask

  task automatic pop_chk();
    logic [31:0] v, e;
    bit under;
    under = en_model && (rx_model == 0);
    e = 0;
    if (en_model && rx_model > 0) begin e = {24'b0, exp_rx.pop_front()}; rx_model--; end
    bus_read(OFS_DATA, v);
    chk("R6 popped receive byte", v, e);
    chk("R6 ev_rx_under after pop", s_ev, under);
  endtask

  task automatic drain();
    cmd_ready = 1;
    for (int i = 0; i < 60 && exp_cmd.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    cmd_ready = 0;
    chk("R2 scoreboard drained", exp_cmd.size(), 0);
  endtask

  task automatic flush_model();
    exp_cmd.delete(); exp_rx.delete(); tx_model = 0; rx_model = 0;
  endtask

  // monitor: compares every word the engine accepts against the scoreboard
  always begin
    @(negedge clk);
    #2;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_cmd.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2 unexpected command actual=0x%0h expected=none", cmd_data);
      end else begin
        chk("R1 command word order/content", cmd_data, exp_cmd.pop_front());
        tx_model--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R10 reset state
    chk("R10 st_tx_low at reset", st_tx_low, 1);
    chk("R10 st_rx_high at reset", st_rx_high, 0);
    chk("R10 cmd_valid at reset", cmd_valid, 0);
    chk("R10 events at reset", {ev_tx_over, ev_rx_under, ev_rx_over}, 0);
    rd_chk("R10 tx level reset", OFS_TX_LVL, 0);
    rd_chk("R10 rx level reset", OFS_RX_LVL, 0);
    rd_chk("R10 enable reset", OFS_ENABLE, 0);
    rd_chk("R10 tx thr reset", OFS_TX_THR, 0);
    rd_chk("R10 rx thr reset", OFS_RX_THR, 0);

    bus_write(OFS_ENABLE, 1); en_model = 1;
    rd_chk("R9 enable readback", OFS_ENABLE, 1);

    // R1 mixed words: write, read, write+stop, read+stop
    push_cmd(10'h0A5); push_cmd(10'h100); push_cmd(10'h2C3); push_cmd(10'h300);
    rd_chk("R3 tx level four", OFS_TX_LVL, 4);
    bus_write(OFS_TX_THR, 3);
    #1 chk("R4 st_tx_low level4 thr3", st_tx_low, 0);
    bus_write(OFS_TX_THR, 4);
    #1 chk("R4 st_tx_low level4 thr4", st_tx_low, 1);
    rd_chk("R4 tx thr readback", OFS_TX_THR, 4);
    bus_write(OFS_TX_THR, DEPTH - 1);
    rd_chk("R4 tx thr depth-1 readback", OFS_TX_THR, DEPTH - 1);
    push_cmd(10'h011); push_cmd(10'h122); push_cmd(10'h233); push_cmd(10'h3FF);
    rd_chk("R3 tx level full", OFS_TX_LVL, DEPTH);
    push_cmd(10'h055);   // R5 dropped
    rd_chk("R5 tx level stays full", OFS_TX_LVL, DEPTH);
    chk("R2 cmd_valid with words", cmd_valid, 1);
    drain();
    rd_chk("R3 tx level after drain", OFS_TX_LVL, 0);

    // receive path
    send_rx(8'h11); send_rx(8'h22); send_rx(8'h33);
    rd_chk("R3 rx level three", OFS_RX_LVL, 3);
    bus_write(OFS_RX_THR, 2);
    #1 chk("R4 st_rx_high level3 thr2", st_rx_high, 1);
    bus_write(OFS_RX_THR, 3);
    #1 chk("R4 st_rx_high level3 thr3", st_rx_high, 0);
    bus_write(OFS_RX_THR, 0);
    pop_chk(); pop_chk(); pop_chk();
    pop_chk();           // R6 empty pop
    for (int i = 0; i < DEPTH + 1; i++) send_rx(8'hA0 + 8'(i));   // R7 last one dropped
    rd_chk("R7 rx level full", OFS_RX_LVL, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_chk();

    // R8 abort flushes both queues
    push_cmd(10'h0C1); push_cmd(10'h1C2); push_cmd(10'h0C3);
    send_rx(8'h5A); send_rx(8'h6B);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    flush_model();
    rd_chk("R8 tx level after abort", OFS_TX_LVL, 0);
    rd_chk("R8 rx level after abort", OFS_RX_LVL, 0);
    drain();
    pop_chk();

    // R9 disable
    push_cmd(10'h0D1); push_cmd(10'h0D2); send_rx(8'h77);
    bus_write(OFS_ENABLE, 0); en_model = 0; flush_model();
    @(negedge clk); #1;
    chk("R9 cmd_valid while disabled", cmd_valid, 0);
    rd_chk("R9 tx level disabled", OFS_TX_LVL, 0);
    rd_chk("R9 rx level disabled", OFS_RX_LVL, 0);
    push_cmd(10'h0E1);
    rd_chk("R9 push ignored while disabled", OFS_TX_LVL, 0);
    send_rx(8'h88);
    rd_chk("R9 byte ignored while disabled", OFS_RX_LVL, 0);
    pop_chk();
    bus_write(OFS_ENABLE, 1); en_model = 1;
    push_cmd(10'h2F0);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule